// File: doc/BRIEF.md
# Dual-Rate Buck PWM Timing Generator

This block is the digital timing core of a synchronous buck converter. A free-running ramp counter is compared against a digital duty command, and the result drives two complementary gate enables: one for the high-side switch and one for the low-side switch. A fixed dead time keeps the two enables apart at every handover. The error amplifier, compensation and gate drivers live outside the block. The duty command comes in as a number of system clocks.

A mode input picks one of two rates. The run rate uses a period of `PERIOD_NORM` clocks and allows any duty from 0 % to 100 %. The standby rate uses half that period, so it switches twice as fast. In standby the duty command is halved so that it keeps the same fraction, and it is capped at 90 % of the shorter period. A new mode and a new duty command are taken only at a period boundary, or while the block is idle.

Over-current is checked only while the high-side enable is on, and only once the enable has been on for `BLANK` clocks. A trip latches the block off until an external clear arrives. Standby mode skips the check entirely.

Top module: `buck_pwm_timer`

## Requirements
- R1: During and directly after reset, `hs_o`, `ls_o` and `fault_o` are all 0.
- R2: In run mode (`stby_i`=0), the rising edges of `hs_o` are exactly `PERIOD_NORM` clocks apart.
- R3: In standby mode (`stby_i`=1), the rising edges of `hs_o` are exactly `PERIOD_NORM/2` clocks apart.
- R4: In run mode, N = min(`duty_i`, `PERIOD_NORM`) clocks are requested as on-time in each period. With 0 < N < P, in each period `hs_o` is high for max(0, N−DT) clocks and `ls_o` is high for max(0, P−N−DT) clocks, where DT is `DEAD_CLKS`.
- R5: In run mode, a command of 0 keeps `ls_o` high for the whole period with `hs_o` low. A command of `PERIOD_NORM` or more keeps `hs_o` high for the whole period with `ls_o` low.
- R6: In standby mode, N = min(`duty_i`>>1, 90 % of P/2, rounded down), and `hs_o`/`ls_o` high times follow the R4 formula with P/2 in place of P. A command of 0 keeps `ls_o` high for the whole period.
- R7: `hs_o` and `ls_o` are never high together. After either one falls, both stay low for `DEAD_CLKS` clocks before the other one rises.
- R8: While `en_i`=0, both enables stay low and the ramp counter stays at 0.
- R9: While `hs_o` has been high for `BLANK` clocks or fewer, `oc_i` has no effect.
- R10: In run mode, `oc_i`=1 once `hs_o` has been high for more than `BLANK` clocks sets `fault_o`. With `oc_i` held high from before the rise, the `hs_o` pulse lasts exactly `BLANK+1` clocks. While `fault_o`=1, both enables stay low, and `fault_o` holds until a clear.
- R11: In standby mode, `oc_i` never sets `fault_o`.
- R12: A one-clock `oc_clr_i` pulse clears `fault_o`, and switching then resumes with the R4 high times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; 0 holds the ramp at 0 and both enables low |
| stby_i | input | 1 | Rate select: 0 run rate, 1 standby rate at double speed |
| duty_i | input | DUTY_W | On-time command in run-rate clocks |
| oc_i | input | 1 | Over-current comparator result, 1 = over limit |
| oc_clr_i | input | 1 | Clears the over-current latch |
| hs_o | output | 1 | High-side gate enable |
| ls_o | output | 1 | Low-side gate enable |
| fault_o | output | 1 | Over-current latch state |

## Verification
The bench sweeps every duty command across both rates and covers the clamp points. These are 0, the on-times at or below the dead time, and commands past 100 % and past the 90 % standby cap. A design that clamped wrongly or halved the command in the wrong mode would show high-time counts off by a few clocks at those points. The bench holds over-current high from the falling edge of `hs_o` and checks that the next pulse lasts exactly `BLANK+1` clocks. A blanking counter off by one would shorten or lengthen that pulse, and sampling inside the blank window would trip on a pulse of `BLANK` clocks. The bench also checks that an over-current held high in standby causes no trip, and that the latch holds until the clear and then releases.

// File: rtl/buck_pwm_pkg.sv
package buck_pwm_pkg;
  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_STBY = 1'b1
  } rate_mode_e;
endpackage

// File: rtl/pwm_ramp.sv
module pwm_ramp
  import buck_pwm_pkg::*;
#(
  parameter int PERIOD_NORM   = 800,
  parameter int DUTY_W        = 10,
  parameter int NORM_MAX_PCT  = 100,
  parameter int STBY_MAX_PCT  = 90,
  localparam int CNT_W        = $clog2(PERIOD_NORM + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              stby_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [CNT_W-1:0]  cnt_o,
  output rate_mode_e        mode_o,
  output logic              req_o
);
  localparam int PERIOD_STBY = PERIOD_NORM / 2;
  localparam int NORM_ON     = PERIOD_NORM * NORM_MAX_PCT / 100;
  localparam int STBY_ON     = PERIOD_STBY * STBY_MAX_PCT / 100;

  logic [CNT_W-1:0] cnt_q, on_q, on_next, last;
  rate_mode_e       mode_q;
  int               dn, cap;

  // on-time in clocks of the selected rate, clamped to its duty limit
  always_comb begin
    dn      = stby_i ? int'(duty_i >> 1) : int'(duty_i);
    cap     = stby_i ? STBY_ON : NORM_ON;
    on_next = CNT_W'((dn > cap) ? cap : dn);
  end

  assign last = (mode_q == MODE_STBY) ? CNT_W'(PERIOD_STBY - 1) : CNT_W'(PERIOD_NORM - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      on_q   <= '0;
      mode_q <= MODE_RUN;
    end else if (!act_i || cnt_q == last) begin
      cnt_q  <= '0;
      on_q   <= on_next;
      mode_q <= rate_mode_e'(stby_i);
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign mode_o = mode_q;
  assign req_o  = act_i && (cnt_q < on_q);
endmodule

// File: rtl/pwm_deadtime.sv
module pwm_deadtime #(
  parameter int DEAD_CLKS = 4,
  localparam int GW       = $clog2(DEAD_CLKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic req_i,
  output logic hs_o,
  output logic ls_o
);
  logic          side_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      side_q <= 1'b0;
      gap_q  <= '0;
    end else if (!act_i) begin
      side_q <= 1'b0;
      gap_q  <= '0;
    end else if (req_i != side_q) begin
      side_q <= req_i;
      gap_q  <= '0;
    end else if (gap_q != GW'(DEAD_CLKS)) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  assign hs_o = act_i &&  side_q && (gap_q == GW'(DEAD_CLKS));
  assign ls_o = act_i && !side_q && (gap_q == GW'(DEAD_CLKS));
endmodule

// File: rtl/pwm_oc_guard.sv
module pwm_oc_guard
  import buck_pwm_pkg::*;
#(
  parameter int BLANK  = 80,
  localparam int BW    = $clog2(BLANK + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hs_i,
  input  rate_mode_e mode_i,
  input  logic       oc_i,
  input  logic       clr_i,
  output logic       fault_o
);
  logic [BW-1:0] blk_q;
  logic          fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q <= '0;
    end else if (!hs_i) begin
      blk_q <= '0;
    end else if (blk_q != BW'(BLANK)) begin
      blk_q <= blk_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
    end else if (clr_i) begin
      fault_q <= 1'b0;
    end else if (hs_i && blk_q == BW'(BLANK) && oc_i && mode_i == MODE_RUN) begin
      fault_q <= 1'b1;
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/buck_pwm_timer.sv
module buck_pwm_timer
  import buck_pwm_pkg::*;
#(
  parameter int PERIOD_NORM  = 800,
  parameter int DUTY_W       = 10,
  parameter int NORM_MAX_PCT = 100,
  parameter int STBY_MAX_PCT = 90,
  parameter int DEAD_CLKS    = 4,
  parameter int BLANK        = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              stby_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              oc_i,
  input  logic              oc_clr_i,
  output logic              hs_o,
  output logic              ls_o,
  output logic              fault_o
);
  localparam int CNT_W = $clog2(PERIOD_NORM + 1);

  logic [CNT_W-1:0] ramp_cnt;
  rate_mode_e       mode;
  logic             act, req, hs, ls, fault;

  assign act = en_i && !fault;

  pwm_ramp #(
    .PERIOD_NORM (PERIOD_NORM),
    .DUTY_W      (DUTY_W),
    .NORM_MAX_PCT(NORM_MAX_PCT),
    .STBY_MAX_PCT(STBY_MAX_PCT)
  ) u_ramp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .act_i (act),
    .stby_i(stby_i),
    .duty_i(duty_i),
    .cnt_o (ramp_cnt),
    .mode_o(mode),
    .req_o (req)
  );

  pwm_deadtime #(.DEAD_CLKS(DEAD_CLKS)) u_dead (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .act_i (act),
    .req_i (req),
    .hs_o  (hs),
    .ls_o  (ls)
  );

  pwm_oc_guard #(.BLANK(BLANK)) u_oc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hs_i   (hs),
    .mode_i (mode),
    .oc_i   (oc_i),
    .clr_i  (oc_clr_i),
    .fault_o(fault)
  );

  assign hs_o    = hs;
  assign ls_o    = ls;
  assign fault_o = fault;
endmodule

// File: rtl/buck_pwm_timer_chk.sv
module buck_pwm_timer_chk #(
  parameter int PERIOD_NORM = 800,
  localparam int CNT_W      = $clog2(PERIOD_NORM + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             oc_i,
  input logic             oc_clr_i,
  input logic             hs_o,
  input logic             ls_o,
  input logic             fault_o,
  input logic [CNT_W-1:0] ramp_i
);
  assert_no_overlap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_o && ls_o));
  assert_gap_after_hs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_o) |-> !ls_o);
  assert_gap_after_ls_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ls_o) |-> !hs_o);
  assert_idle_ramp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> ramp_i == '0);
  assert_ramp_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_i < CNT_W'(PERIOD_NORM));
  assert_blank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |=> !fault_o);
  assert_trip_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(hs_o) && $past(oc_i));
  assert_fault_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fault_o) && !$past(oc_clr_i) |-> fault_o);
endmodule

bind buck_pwm_timer buck_pwm_timer_chk #(.PERIOD_NORM(PERIOD_NORM)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .oc_i    (oc_i),
  .oc_clr_i(oc_clr_i),
  .hs_o    (hs_o),
  .ls_o    (ls_o),
  .fault_o (fault_o),
  .ramp_i  (ramp_cnt)
);

// File: tb/tb_buck_pwm_timer.sv
module tb_buck_pwm_timer;
  localparam int P  = 20;
  localparam int PS = P / 2;
  localparam int DW = 6;
  localparam int DT = 2;
  localparam int BK = 4;
  localparam int SMAX = PS * 90 / 100;

  logic clk = 1'b0, rst_ni = 1'b0, en = 1'b0, stby = 1'b0, oc = 1'b0, clr = 1'b0;
  logic [DW-1:0] duty = '0;
  logic hs, ls, fault;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  buck_pwm_timer #(
    .PERIOD_NORM(P), .DUTY_W(DW), .NORM_MAX_PCT(100), .STBY_MAX_PCT(90),
    .DEAD_CLKS(DT), .BLANK(BK)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .stby_i(stby), .duty_i(duty),
    .oc_i(oc), .oc_clr_i(clr), .hs_o(hs), .ls_o(ls), .fault_o(fault)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input int len, output int h, output int l, output int b);
    h = 0; l = 0; b = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      h += int'(hs); l += int'(ls); b += int'(hs && ls);
    end
  endtask

  task automatic rise_gap(output int gap);
    logic prev;
    int k;
    gap = -1;
    prev = hs;
    k = 0;
    while (!(hs && !prev) && k < 200) begin prev = hs; @(negedge clk); k++; end
    if (k >= 200) return;
    prev = hs;
    @(negedge clk);
    gap = 1;
    while (!(hs && !prev) && gap < 200) begin prev = hs; @(negedge clk); gap++; end
  endtask

  function automatic int exp_hs(input int n, input int per);
    if (n >= per) return per;
    if (n == 0) return 0;
    return (n > DT) ? n - DT : 0;
  endfunction

  function automatic int exp_ls(input int n, input int per);
    if (n >= per) return 0;
    if (n == 0) return per;
    return (per - n - DT > 0) ? per - n - DT : 0;
  endfunction

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    int h, l, b, g, n;
    wait_clk(3);
    check("R1 hs in reset", int'(hs), 0);
    check("R1 ls in reset", int'(ls), 0);
    check("R1 fault in reset", int'(fault), 0);
    rst_ni = 1'b1;
    wait_clk(2);
    check("R1 hs after reset", int'(hs), 0);
    check("R1 ls after reset", int'(ls), 0);

    // R8: disabled holds both low
    duty = 6'd10;
    measure(2 * P, h, l, b);
    check("R8 hs idle", h, 0);
    check("R8 ls idle", l, 0);

    en = 1'b1;
    wait_clk(3 * P);
    rise_gap(g);
    check("R2 run period", g, P);

    // R4/R5 run-mode sweep
    for (int d = 0; d < 26; d++) begin
      duty = DW'(d);
      wait_clk(3 * P);
      measure(P, h, l, b);
      n = (d > P) ? P : d;
      check($sformatf("R4 run hs d=%0d", d), h, exp_hs(n, P));
      check($sformatf("R4 run ls d=%0d", d), l, exp_ls(n, P));
      check("R7 overlap", b, 0);
    end
    duty = 6'd63;
    wait_clk(3 * P);
    measure(P, h, l, b);
    check("R5 full hs", h, P);
    check("R5 full ls", l, 0);
    duty = 6'd0;
    wait_clk(3 * P);
    measure(P, h, l, b);
    check("R5 zero ls", l, P);

    // R3/R6 standby sweep
    stby = 1'b1;
    duty = 6'd10;
    wait_clk(3 * P);
    rise_gap(g);
    check("R3 stby period", g, PS);
    for (int d = 0; d < 40; d++) begin
      duty = DW'(d);
      wait_clk(3 * P);
      measure(PS, h, l, b);
      n = ((d >> 1) > SMAX) ? SMAX : (d >> 1);
      check($sformatf("R6 stby hs d=%0d", d), h, exp_hs(n, PS));
      check($sformatf("R6 stby ls d=%0d", d), l, exp_ls(n, PS));
      check("R7 overlap", b, 0);
    end

    // R11: standby ignores over-current
    duty = 6'd63;
    oc = 1'b1;
    measure(4 * PS, h, l, b);
    check("R11 no trip", int'(fault), 0);
    check("R11 hs keeps running", h, 4 * (SMAX - DT));
    oc = 1'b0;

    // R9: pulses no longer than the blank never trip
    stby = 1'b0;
    duty = DW'(BK + DT);
    wait_clk(3 * P);
    oc = 1'b1;
    measure(4 * P, h, l, b);
    check("R9 no trip", int'(fault), 0);
    check("R9 hs width", h, 4 * BK);
    oc = 1'b0;

    // R10: trip after blank, latched off
    duty = 6'd15;
    wait_clk(3 * P);
    while (!hs) @(negedge clk);
    while (hs) @(negedge clk);
    oc = 1'b1;
    while (!hs) @(negedge clk);
    g = 0;
    while (hs && g < 100) begin g++; @(negedge clk); end
    check("R10 pulse width", g, BK + 1);
    check("R10 fault set", int'(fault), 1);
    oc = 1'b0;
    measure(3 * P, h, l, b);
    check("R10 hs off", h, 0);
    check("R10 ls off", l, 0);
    check("R10 fault held", int'(fault), 1);

    // R12: clear resumes switching
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R12 fault cleared", int'(fault), 0);
    wait_clk(3 * P);
    measure(P, h, l, b);
    check("R12 hs resumed", h, 15 - DT);
    check("R12 ls resumed", l, P - 15 - DT);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule